// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block gives a five-stage in-order pipeline precise exceptions and interrupts. Each stage may flag a problem with the instruction it holds: a bad fetch address in fetch, an undefined opcode in decode, an arithmetic overflow in execute, or a bad data address in the memory stage. These flags do not act where they are raised. They travel with the instruction and its PC through per-stage registers. Only when the instruction reaches the commit point in the memory stage does the unit decide whether the instruction completes or traps.

At the commit point the unit takes one of three actions. A trap records a cause code and the exception PC, kills every younger stage and the writeback of the trapping instruction, switches to kernel mode with interrupts masked, and steers fetch to a fixed handler address. A return-from-exception steers fetch back to the saved PC, unmasks interrupts and returns to user mode. Otherwise the instruction is allowed to write back. External interrupt requests are considered only at the commit point and only when a valid instruction sits there. The datapath, ALU and memories sit outside the block. The pipeline advances every cycle.

Top module: `exc_commit_unit`

## Requirements
- R1: After reset the recorded cause is 0, the exception PC is 0, interrupts are enabled, the mode is user (kernel_mode low), and there is no redirect, flush or trap.
- R2: A trap writes a 3-bit cause code to `cause`: 1 fetch address fault, 2 illegal opcode, 3 overflow, 4 data address fault, 5 external interrupt. The same trap writes the PC of the instruction at the commit point to `epc`. Both values are visible from the cycle after the trap.
- R3: A fault flagged in fetch, decode or execute has no effect until its instruction reaches the memory stage. That happens three clock edges after fetch accepts it, and `exc_taken` stays low before then.
- R4: When one instruction collects several faults, the fault from the earliest stage decides the cause code.
- R5: An external interrupt that arrives while interrupts are enabled, with a valid instruction at the commit point, is taken with cause 5 even if that instruction also faults. `epc` receives that instruction's PC and the instruction does not write back.
- R6: In a trap cycle, `flush` and `redirect_valid` are high, `redirect_pc` equals HANDLER_PC and `wb_en` is low. Instructions younger than the trapping one never write back and never trap.
- R7: A trap sets kernel mode and masks interrupts. While interrupts are masked, an interrupt request is ignored: the instruction at the commit point writes back.
- R8: A valid return-from-exception at the commit point with no trap raises `flush` and `redirect_valid` with `redirect_pc` equal to `epc`. From the next cycle interrupts are enabled and the mode is user.
- R9: A bubble never traps. Fault flags raised on an empty stage are ignored, and an interrupt with no valid instruction at the commit point is not taken.
- R10: A valid instruction at the commit point with no fault and no interrupt asserts `wb_en` with no flush or redirect, and leaves `cause` and `epc` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| f_valid | input | 1 | Fetch stage holds an instruction |
| f_pc | input | PC_W | PC of the fetched instruction |
| f_addr_fault | input | 1 | Fetch address fault on the fetched instruction |
| d_illegal_op | input | 1 | Decode found an illegal opcode |
| e_overflow | input | 1 | Execute produced an arithmetic overflow |
| m_daddr_fault | input | 1 | Memory stage data address fault |
| m_is_eret | input | 1 | Instruction at commit is a return-from-exception |
| irq_req | input | 1 | External interrupt request |
| exc_taken | output | 1 | A trap is taken this cycle |
| flush | output | 1 | Kill all stages and the commit-stage writeback |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | PC_W | Restart address for fetch |
| wb_en | output | 1 | Instruction at commit may write back |
| cause | output | 3 | Recorded cause code |
| epc | output | PC_W | Recorded exception PC |
| int_en | output | 1 | Interrupts enabled |
| kernel_mode | output | 1 | Kernel mode active |

## Verification
A corrupted per-stage fault register shows up as a wrong cause code, or a missing trap, in the same cycle the instruction reaches commit. A bad valid bit shows up as a bubble that traps, or as a killed instruction that still raises `wb_en`, within three cycles of the flush. Errors in the mode or enable state show up one cycle after a trap or return, on `int_en` and `kernel_mode`. They also show up on the next interrupt, which is then taken or ignored against the rule. Corrupted saved-PC state shows up on `epc` the cycle after the trap, and on `redirect_pc` when the return-from-exception commits.

// File: rtl/exc_commit_pkg.sv
package exc_commit_pkg;
   localparam int CAUSE_W = 3;
   localparam int N_PRE_STAGES = 3;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_NONE    = 3'd0,
      CAUSE_FETCH   = 3'd1,
      CAUSE_ILLEGAL = 3'd2,
      CAUSE_OVF     = 3'd3,
      CAUSE_DADDR   = 3'd4,
      CAUSE_IRQ     = 3'd5
   } cause_e;
endpackage

// File: rtl/exc_irq_sync.sv
module exc_irq_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_in,
   output logic irq_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign irq_out = irq_in;
      end else begin : g_flops
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], irq_in} & {STAGES{1'b1}};
         end
         assign irq_out = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
   import exc_commit_pkg::*;
#(
   parameter int     PC_W       = 32,
   parameter cause_e LOCAL_CODE = CAUSE_FETCH
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            kill,
   input  logic            in_valid,
   input  logic [PC_W-1:0] in_pc,
   input  cause_e          in_cause,
   input  logic            local_fault,
   output logic            out_valid,
   output logic [PC_W-1:0] out_pc,
   output cause_e          out_cause
);
   cause_e merged;

   // An older flag already carried by the instruction keeps precedence
   always_comb begin
      if (!in_valid)                merged = CAUSE_NONE;
      else if (in_cause != CAUSE_NONE) merged = in_cause;
      else if (local_fault)         merged = LOCAL_CODE;
      else                          merged = CAUSE_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pc    <= '0;
         out_cause <= CAUSE_NONE;
      end else begin
         out_valid <= in_valid & ~kill;
         out_pc    <= in_pc;
         out_cause <= kill ? CAUSE_NONE : merged;
      end
   end
endmodule

// File: rtl/exc_commit_ctrl.sv
module exc_commit_ctrl
   import exc_commit_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
   input  logic            m_valid,
   input  cause_e          m_cause,
   input  logic            m_daddr_fault,
   input  logic            m_is_eret,
   input  logic            irq,
   input  logic            int_en,
   input  logic [PC_W-1:0] epc,
   output logic            take,
   output cause_e          take_cause,
   output logic            eret_take,
   output logic            wb_en,
   output logic            redirect_valid,
   output logic [PC_W-1:0] redirect_pc
);
   cause_e sync_cause;
   logic   irq_hit;

   always_comb begin
      if (m_cause != CAUSE_NONE) sync_cause = m_cause;
      else if (m_daddr_fault)    sync_cause = CAUSE_DADDR;
      else                       sync_cause = CAUSE_NONE;
   end

   assign irq_hit        = m_valid & irq & int_en;
   assign take           = m_valid & (irq_hit | (sync_cause != CAUSE_NONE));
   assign take_cause     = irq_hit ? CAUSE_IRQ : sync_cause;
   assign eret_take      = m_valid & m_is_eret & ~take;
   assign wb_en          = m_valid & ~take;
   assign redirect_valid = take | eret_take;
   assign redirect_pc    = take ? HANDLER_PC : epc;
endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
   import exc_commit_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  cause_e          take_cause,
   input  logic [PC_W-1:0] m_pc,
   input  logic            eret_take,
   output cause_e          cause_q,
   output logic [PC_W-1:0] epc_q,
   output logic            int_en_q,
   output logic            kernel_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q  <= CAUSE_NONE;
         epc_q    <= '0;
         int_en_q <= 1'b1;
         kernel_q <= 1'b0;
      end else if (take) begin
         cause_q  <= take_cause;
         epc_q    <= m_pc;
         int_en_q <= 1'b0;
         kernel_q <= 1'b1;
      end else if (eret_take) begin
         int_en_q <= 1'b1;
         kernel_q <= 1'b0;
      end
   end
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit
   import exc_commit_pkg::*;
#(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = 32'h8000_0000,
   parameter int              IRQ_SYNC   = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               f_valid,
   input  logic [PC_W-1:0]    f_pc,
   input  logic               f_addr_fault,
   input  logic               d_illegal_op,
   input  logic               e_overflow,
   input  logic               m_daddr_fault,
   input  logic               m_is_eret,
   input  logic               irq_req,
   output logic               exc_taken,
   output logic               flush,
   output logic               redirect_valid,
   output logic [PC_W-1:0]    redirect_pc,
   output logic               wb_en,
   output logic [CAUSE_W-1:0] cause,
   output logic [PC_W-1:0]    epc,
   output logic               int_en,
   output logic               kernel_mode
);
   generate
      if (PC_W < 8) begin : g_bad_width
         $error("exc_commit_unit: PC_W must be at least 8");
      end
      if (HANDLER_PC[1:0] != 2'b00) begin : g_bad_handler
         $error("exc_commit_unit: HANDLER_PC must be word aligned");
      end
      if (IRQ_SYNC < 0 || IRQ_SYNC > 3) begin : g_bad_sync
         $error("exc_commit_unit: IRQ_SYNC must be 0 to 3");
      end
   endgenerate

   // index 0 is the fetch input, index N_PRE_STAGES is the commit stage
   logic            st_valid [0:N_PRE_STAGES];
   logic [PC_W-1:0] st_pc    [0:N_PRE_STAGES];
   cause_e          st_cause [0:N_PRE_STAGES];
   logic [N_PRE_STAGES-1:0] stage_fault;

   logic            m_valid;
   logic [PC_W-1:0] m_pc;
   cause_e          m_cause;
   logic            irq_eff;
   logic            take;
   cause_e          take_cause;
   logic            eret_take;
   cause_e          cause_q;
   logic            kill;

   assign st_valid[0] = f_valid;
   assign st_pc[0]    = f_pc;
   assign st_cause[0] = CAUSE_NONE;
   assign stage_fault = {e_overflow, d_illegal_op, f_addr_fault};

   genvar gi;
   generate
      for (gi = 0; gi < N_PRE_STAGES; gi++) begin : g_stage
         exc_stage_reg #(
            .PC_W      (PC_W),
            .LOCAL_CODE(cause_e'(gi + 1))
         ) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .kill       (kill),
            .in_valid   (st_valid[gi]),
            .in_pc      (st_pc[gi]),
            .in_cause   (st_cause[gi]),
            .local_fault(stage_fault[gi]),
            .out_valid  (st_valid[gi+1]),
            .out_pc     (st_pc[gi+1]),
            .out_cause  (st_cause[gi+1])
         );
      end
   endgenerate

   assign m_valid = st_valid[N_PRE_STAGES];
   assign m_pc    = st_pc[N_PRE_STAGES];
   assign m_cause = st_cause[N_PRE_STAGES];

   exc_irq_sync #(.STAGES(IRQ_SYNC)) u_irq_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_in (irq_req),
      .irq_out(irq_eff)
   );

   exc_commit_ctrl #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_ctrl (
      .m_valid       (m_valid),
      .m_cause       (m_cause),
      .m_daddr_fault (m_daddr_fault),
      .m_is_eret     (m_is_eret),
      .irq           (irq_eff),
      .int_en        (int_en),
      .epc           (epc),
      .take          (take),
      .take_cause    (take_cause),
      .eret_take     (eret_take),
      .wb_en         (wb_en),
      .redirect_valid(redirect_valid),
      .redirect_pc   (redirect_pc)
   );

   exc_status_regs #(.PC_W(PC_W)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .take_cause(take_cause),
      .m_pc      (m_pc),
      .eret_take (eret_take),
      .cause_q   (cause_q),
      .epc_q     (epc),
      .int_en_q  (int_en),
      .kernel_q  (kernel_mode)
   );

   assign kill      = take | eret_take;
   assign flush     = kill;
   assign exc_taken = take;
   assign cause     = cause_q;
endmodule

// File: rtl/exc_commit_checks.sv
module exc_commit_checks #(
   parameter int              PC_W       = 32,
   parameter logic [PC_W-1:0] HANDLER_PC = '0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            exc_taken,
   input logic            eret_take,
   input logic            flush,
   input logic            redirect_valid,
   input logic [PC_W-1:0] redirect_pc,
   input logic            wb_en,
   input logic            int_en,
   input logic            kernel_mode,
   input logic [PC_W-1:0] epc,
   input logic            m_valid,
   input logic [PC_W-1:0] m_pc
);
   AST_TRAP_TO_HANDLER: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken |-> (flush && redirect_valid && redirect_pc == HANDLER_PC)); // R6
   AST_TRAP_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken |-> !wb_en); // R6
   AST_TRAP_EMPTIES_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken |=> !m_valid); // R6
   AST_TRAP_ENTERS_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken |=> (kernel_mode && !int_en)); // R7
   AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_taken |=> (epc == $past(m_pc))); // R2
   AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !m_valid |-> (!exc_taken && !wb_en && !redirect_valid)); // R9
   AST_ERET_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      eret_take |-> (flush && redirect_pc == epc)); // R8
   AST_ERET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      eret_take |=> (int_en && !kernel_mode)); // R8
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exc_taken, eret_take})); // R8
endmodule

bind exc_commit_unit exc_commit_checks #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) u_checks (
   .clk           (clk),
   .rst_n         (rst_n),
   .exc_taken     (exc_taken),
   .eret_take     (eret_take),
   .flush         (flush),
   .redirect_valid(redirect_valid),
   .redirect_pc   (redirect_pc),
   .wb_en         (wb_en),
   .int_en        (int_en),
   .kernel_mode   (kernel_mode),
   .epc           (epc),
   .m_valid       (m_valid),
   .m_pc          (m_pc)
);

// File: tb/exc_commit_unit_bench.sv
module exc_commit_unit_bench;
   localparam int          CLK_PERIOD = 10;
   localparam int          PC_W       = 32;
   localparam logic [31:0] HANDLER    = 32'h8000_0000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            f_valid = 1'b0;
   logic [PC_W-1:0] f_pc = '0;
   logic            f_addr_fault = 1'b0;
   logic            d_illegal_op = 1'b0;
   logic            e_overflow = 1'b0;
   logic            m_daddr_fault = 1'b0;
   logic            m_is_eret = 1'b0;
   logic            irq_req = 1'b0;
   logic            exc_taken, flush, redirect_valid, wb_en, int_en, kernel_mode;
   logic [PC_W-1:0] redirect_pc, epc;
   logic [2:0]      cause;

   int n_checks = 0;
   int n_fail   = 0;

   // results of the most recent instruction run
   logic            o_taken, o_flush, o_rv, o_wb, o_early;
   logic [PC_W-1:0] o_rpc;

   exc_commit_unit #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) u_exc_commit_unit (
      .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_pc(f_pc),
      .f_addr_fault(f_addr_fault), .d_illegal_op(d_illegal_op),
      .e_overflow(e_overflow), .m_daddr_fault(m_daddr_fault),
      .m_is_eret(m_is_eret), .irq_req(irq_req), .exc_taken(exc_taken),
      .flush(flush), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .wb_en(wb_en), .cause(cause), .epc(epc), .int_en(int_en),
      .kernel_mode(kernel_mode)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_inputs();
      f_valid = 0; f_addr_fault = 0; d_illegal_op = 0; e_overflow = 0;
      m_daddr_fault = 0; m_is_eret = 0; irq_req = 0;
   endtask

   // One instruction through F, D, E into M with per-stage fault flags.
   task automatic run_instr(input logic [31:0] pc, input logic ff, input logic ill,
                            input logic ovf, input logic daf, input logic irq,
                            input logic eret);
      o_early = 0;
      @(negedge clk);
      f_valid = 1; f_pc = pc; f_addr_fault = ff;
      #1 o_early |= exc_taken;
      @(negedge clk);
      clear_inputs(); d_illegal_op = ill;
      #1 o_early |= exc_taken;
      @(negedge clk);
      clear_inputs(); e_overflow = ovf;
      #1 o_early |= exc_taken;
      @(negedge clk);
      clear_inputs(); m_daddr_fault = daf; irq_req = irq; m_is_eret = eret;
      #1;
      o_taken = exc_taken; o_flush = flush; o_rv = redirect_valid;
      o_rpc = redirect_pc; o_wb = wb_en;
      @(negedge clk);
      clear_inputs();
      #1;
   endtask

   task automatic expect_trap(input string req, input logic [31:0] pc, input logic [2:0] code);
      check({req, " no early trap (R3)"}, {31'b0, o_early}, 32'd0);
      check({req, " trap taken"}, {31'b0, o_taken}, 32'd1);
      check({req, " redirect to handler (R6)"}, o_rpc, HANDLER);
      check({req, " flush/redirect/no wb (R6)"}, {29'b0, o_flush, o_rv, o_wb}, 32'b110);
      check({req, " cause"}, {29'b0, cause}, {29'b0, code});
      check({req, " epc"}, epc, pc);
      check({req, " kernel, irq masked (R7)"}, {30'b0, kernel_mode, int_en}, 32'b10);
   endtask

   task automatic do_eret(input logic [31:0] pc);
      logic [31:0] saved;
      saved = epc;
      run_instr(pc, 0, 0, 0, 0, 0, 1);
      check("R8 eret redirect to epc", o_rpc, saved);
      check("R8 eret flush/redirect, no trap", {29'b0, o_flush, o_rv, o_taken}, 32'b110);
      check("R8 eret restores user mode, irq enabled", {30'b0, kernel_mode, int_en}, 32'b01);
   endtask

   task automatic t_reset();
      check("R1 reset cause", {29'b0, cause}, 32'd0);
      check("R1 reset epc", epc, 32'd0);
      check("R1 reset mode/enable", {30'b0, kernel_mode, int_en}, 32'b01);
      check("R1 reset no redirect/flush/trap", {29'b0, redirect_valid, flush, exc_taken}, 32'd0);
   endtask

   task automatic t_normal();
      run_instr(32'h0000_0100, 0, 0, 0, 0, 0, 0);
      check("R10 wb_en no redirect", {29'b0, o_wb, o_rv, o_flush}, 32'b100);
      check("R10 cause/epc unchanged", {29'b0, cause}, 32'd0);
      check("R10 epc unchanged", epc, 32'd0);
   endtask

   task automatic t_single_causes();
      run_instr(32'h0000_0200, 1, 0, 0, 0, 0, 0);
      expect_trap("R2 fetch fault", 32'h0000_0200, 3'd1);
      do_eret(32'h0000_1000);
      run_instr(32'h0000_0204, 0, 1, 0, 0, 0, 0);
      expect_trap("R2 illegal", 32'h0000_0204, 3'd2);
      do_eret(32'h0000_1004);
      run_instr(32'h0000_0208, 0, 0, 1, 0, 0, 0);
      expect_trap("R2 overflow", 32'h0000_0208, 3'd3);
      do_eret(32'h0000_1008);
      run_instr(32'h0000_020c, 0, 0, 0, 1, 0, 0);
      expect_trap("R2 data addr", 32'h0000_020c, 3'd4);
      do_eret(32'h0000_100c);
   endtask

   task automatic t_priority();
      run_instr(32'h0000_0300, 1, 0, 1, 1, 0, 0);
      expect_trap("R4 fetch beats overflow", 32'h0000_0300, 3'd1);
      do_eret(32'h0000_1010);
      run_instr(32'h0000_0304, 0, 1, 0, 1, 0, 0);
      expect_trap("R4 illegal beats data addr", 32'h0000_0304, 3'd2);
      do_eret(32'h0000_1014);
   endtask

   task automatic t_irq();
      run_instr(32'h0000_0400, 0, 0, 1, 0, 1, 0);
      expect_trap("R5 irq overrides overflow", 32'h0000_0400, 3'd5);
      // interrupts now masked
      run_instr(32'h0000_0404, 0, 0, 0, 0, 1, 0);
      check("R7 masked irq ignored: wb, no trap", {30'b0, o_wb, o_taken}, 32'b10);
      check("R7 masked irq keeps cause", {29'b0, cause}, 32'd5);
      do_eret(32'h0000_1018);
      check("R8 eret target was epc of irq", o_rpc, 32'h0000_0400);
   endtask

   task automatic t_bubbles();
      logic seen;
      seen = 0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         clear_inputs();
         f_addr_fault = 1; d_illegal_op = 1; e_overflow = 1;
         m_daddr_fault = 1; irq_req = 1;
         #1 seen |= exc_taken | wb_en | redirect_valid;
      end
      @(negedge clk);
      clear_inputs();
      #1 seen |= exc_taken | wb_en | redirect_valid;
      check("R9 bubbles never trap or commit", {31'b0, seen}, 32'd0);
      check("R9 state untouched by bubbles", {29'b0, cause}, 32'd5);
   endtask

   task automatic t_kill_younger();
      logic seen;
      seen = 0;
      @(negedge clk); clear_inputs(); f_valid = 1; f_pc = 32'h0000_0500;
      @(negedge clk); clear_inputs(); f_valid = 1; f_pc = 32'h0000_0504;
      @(negedge clk); clear_inputs(); f_valid = 1; f_pc = 32'h0000_0508; e_overflow = 1;
      @(negedge clk); clear_inputs(); e_overflow = 1;
      #1;
      check("R6 older overflow trap taken", {31'b0, exc_taken}, 32'd1);
      check("R6 trap in same cycle: flush, no wb", {30'b0, flush, wb_en}, 32'b10);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); clear_inputs();
         #1 seen |= exc_taken | wb_en;
      end
      check("R6 younger killed: no wb, no trap", {31'b0, seen}, 32'd0);
      check("R6 epc kept at older pc", epc, 32'h0000_0500);
      check("R6 cause is overflow", {29'b0, cause}, 32'd3);
      do_eret(32'h0000_101c);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      clear_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      t_reset();
      t_normal();
      t_single_causes();
      t_priority();
      t_irq();
      t_bubbles();
      t_kill_younger();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule